// File: doc/BRIEF.md
# Prescaled Selectable Baud-Rate Generator

This block produces the two timing enables a serial port needs: a sampling enable for the receiver and a bit enable for the transmitter. It starts from a system clock of about 8 MHz. A fixed divide-by-13 prescaler advances an 8-bit binary counter. A 3-bit rate code picks one counter stage, and the carry out of that stage marks one sampling period. A divide-by-8 stage then turns every eighth sampling pulse into a transmit bit pulse.

Each rate code step halves the rate. Code 0 gives 38462 baud with eight samples per bit, and code 7 gives 300.5 baud. Both outputs are one-cycle enables in the system clock domain, not derived clocks, so the serial logic that uses them stays on the single clock. The rate code is read only at prescaler wrap cycles. The counter never restarts when the code changes, so a new code takes effect at the next wrap and cannot create a partial-width pulse.

The design has no state machine. It is a chain of three counters: the prescaler, the stage counter and the oversampling divider. Both outputs are registered in the top module.

Top module: `brg_baud_gen`

## Requirements
- R1: While `rst_ni` is low, `rxc_o` and `txc_o` are 0 and all three counters are cleared. After release, count the clock edges e = 1, 2, ... from the first edge. With code k held, the first `rxc_o` pulse is visible after edge 13·2^(k+1).
- R2: `rxc_o` can be high only in the cycle after a prescaler wrap, that is, after edge e where e is a multiple of 13.
- R3: With rate code k (0..7) held, `rxc_o` pulses every 13·2^(k+1) clocks. Code 0 gives 26 clocks (38462 baud × 8) and code 7 gives 3328 clocks (300.5 baud × 8).
- R4: Every `rxc_o` and `txc_o` pulse is exactly one clock wide.
- R5: `txc_o` pulses together with every eighth `rxc_o` pulse counted since reset (the 8th, 16th, ...) and never at any other time.
- R6: The code is sampled only at the wrap edge. Let edge 13m be a wrap and k the code present at that edge. A pulse follows edge 13m exactly when m is a multiple of 2^(k+1). Code changes between wraps have no effect.
- R7: A change of code does not restart the stage counter or the divide-by-8 count. The pulse positions after a change follow R6 using the wrap count since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| baud_sel_i | input | 3 | Rate code k; sampling period is 13·2^(k+1) clocks |
| rxc_o | output | 1 | Receiver sampling enable, one cycle wide |
| txc_o | output | 1 | Transmit bit enable, one cycle wide, every eighth sampling enable |

## Verification
The sampling pulse and the transmit pulse fall in the same cycle on every eighth sampling period. A rate-code change can also land on the very wrap that would emit a pulse. The bench provokes both by sweeping every code from reset. It also switches codes exactly one edge before a wrap and toggles the code between wraps. Each cycle it compares both outputs against a model built from the wrap count since reset, the code present at each wrap, and the running count of sampling pulses.

// File: rtl/brg_pkg.sv
package brg_pkg;
    localparam int unsigned BRG_PRESCALE   = 13;
    localparam int unsigned BRG_TAP_BITS   = 8;
    localparam int unsigned BRG_OVERSAMPLE = 8;
endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
    parameter int unsigned PRESCALE = brg_pkg::BRG_PRESCALE
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic wrap_o
);
    localparam int unsigned PRE_W = $clog2(PRESCALE);

    logic [PRE_W-1:0] phase_q;

    assign wrap_o = (phase_q == PRE_W'(PRESCALE - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else if (wrap_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/brg_tap_counter.sv
module brg_tap_counter #(
    parameter int unsigned TAP_BITS = brg_pkg::BRG_TAP_BITS,
    localparam int unsigned SEL_W   = $clog2(TAP_BITS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tap_o
);
    logic [TAP_BITS-1:0] stage_q;
    logic [TAP_BITS-1:0] carry;

    for (genvar k = 0; k < TAP_BITS; k++) begin : g_carry
        assign carry[k] = &stage_q[k:0];
    end

    assign tap_o = step_i & carry[sel_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
        end else if (step_i) begin
            stage_q <= stage_q + TAP_BITS'(1);
        end
    end
endmodule

// File: rtl/brg_oversample_div.sv
module brg_oversample_div #(
    parameter int unsigned OVERSAMPLE = brg_pkg::BRG_OVERSAMPLE
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    output logic last_o
);
    localparam int unsigned DIV_W = $clog2(OVERSAMPLE);

    logic [DIV_W-1:0] div_q;
    logic             at_end;

    assign at_end = (div_q == DIV_W'(OVERSAMPLE - 1));
    assign last_o = tick_i & at_end;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else if (tick_i) begin
            div_q <= at_end ? '0 : div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/brg_baud_gen.sv
module brg_baud_gen #(
    parameter int unsigned PRESCALE   = brg_pkg::BRG_PRESCALE,
    parameter int unsigned TAP_BITS   = brg_pkg::BRG_TAP_BITS,
    parameter int unsigned OVERSAMPLE = brg_pkg::BRG_OVERSAMPLE,
    localparam int unsigned SEL_W     = $clog2(TAP_BITS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] baud_sel_i,
    output logic             rxc_o,
    output logic             txc_o
);
    logic wrap;
    logic tap;
    logic last;
    logic rxc_q;
    logic txc_q;

    brg_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wrap_o (wrap)
    );

    brg_tap_counter #(.TAP_BITS(TAP_BITS)) u_tap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (wrap),
        .sel_i  (baud_sel_i),
        .tap_o  (tap)
    );

    brg_oversample_div #(.OVERSAMPLE(OVERSAMPLE)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tap),
        .last_o (last)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rxc_q <= 1'b0;
            txc_q <= 1'b0;
        end else begin
            rxc_q <= tap;
            txc_q <= last;
        end
    end

    assign rxc_o = rxc_q;
    assign txc_o = txc_q;
endmodule

// File: rtl/brg_baud_gen_chk.sv
module brg_baud_gen_chk #(
    parameter int unsigned PRESCALE   = brg_pkg::BRG_PRESCALE,
    parameter int unsigned OVERSAMPLE = brg_pkg::BRG_OVERSAMPLE
) (
    input logic clk_i,
    input logic rst_ni,
    input logic rxc_i,
    input logic txc_i
);
    int unsigned ph_q;
    int unsigned rx_seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_q      <= 0;
            rx_seen_q <= 0;
        end else begin
            ph_q <= (ph_q == PRESCALE - 1) ? 0 : ph_q + 1;
            if (rxc_i) begin
                rx_seen_q <= txc_i ? 0 : rx_seen_q + 1;
            end
        end
    end

    a_r2_rxc_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rxc_i |-> (ph_q == 0));

    a_r4_rxc_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rxc_i |=> !rxc_i);

    a_r4_txc_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
        txc_i |=> !txc_i);

    a_r5_txc_with_rxc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        txc_i |-> rxc_i);

    a_r5_txc_on_nth: assert property (@(posedge clk_i) disable iff (!rst_ni)
        txc_i |-> (rx_seen_q == OVERSAMPLE - 1));

    a_r5_txc_not_missed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rxc_i && rx_seen_q == OVERSAMPLE - 1) |-> txc_i);
endmodule

bind brg_baud_gen brg_baud_gen_chk #(
    .PRESCALE   (PRESCALE),
    .OVERSAMPLE (OVERSAMPLE)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rxc_i  (rxc_o),
    .txc_i  (txc_o)
);

// File: tb/brg_baud_gen_tb.sv
module brg_baud_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    localparam int VEC_N = 8;
    localparam int VEC_PER [VEC_N] = '{26, 52, 104, 208, 416, 832, 1664, 3328};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       rxc;
    logic       txc;

    int n_checks = 0;
    int n_fail   = 0;
    int edge_n   = 0;
    int rx_n     = 0;
    int cycles   = 0;
    int win_err  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    brg_baud_gen dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .baud_sel_i (sel),
        .rxc_o      (rxc),
        .txc_o      (txc)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // One clock edge; compares both outputs against the wrap-count model (R2, R5, R6, R7).
    task automatic step();
        int  s;
        bit  exp_rx;
        bit  exp_tx;
        s = int'(sel);
        @(posedge clk);
        #1;
        edge_n++;
        cycles++;
        exp_rx = (edge_n % 13 == 0) && (((edge_n / 13) % (2 << s)) == 0);
        exp_tx = 1'b0;
        if (exp_rx) begin
            rx_n++;
            exp_tx = (rx_n % 8 == 0);
        end
        if (rxc !== exp_rx || txc !== exp_tx) win_err++;
    endtask

    task automatic do_reset(input logic [2:0] s);
        rst_n = 1'b0;
        sel   = s;
        @(posedge clk);
        #1;
        check("R1 rxc in reset", int'(rxc), 0);
        check("R1 txc in reset", int'(txc), 0);
        #2;
        rst_n  = 1'b1;
        edge_n = 0;
        rx_n   = 0;
    endtask

    initial begin
        #(longint'(WATCHDOG) * CLK_PERIOD);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
        finish_run();
    end

    initial begin
        int first_rx;
        int second_rx;
        int first_tx;
        int t0;

        // Table walk: every rate code from reset (R1, R3, R5).
        for (int v = 0; v < VEC_N; v++) begin
            do_reset(3'(v));
            first_rx  = 0;
            second_rx = 0;
            first_tx  = 0;
            win_err   = 0;
            while (first_tx == 0) begin
                step();
                if (rxc === 1'b1) begin
                    if (first_rx == 0) first_rx = edge_n;
                    else if (second_rx == 0) second_rx = edge_n;
                end
                if (txc === 1'b1) first_tx = edge_n;
                if (edge_n > 9 * VEC_PER[v]) first_tx = -1;
            end
            check("R1 first rxc edge", first_rx, VEC_PER[v]);
            check("R3 rxc period", second_rx - first_rx, VEC_PER[v]);
            check("R5 first txc edge", first_tx, 8 * VEC_PER[v]);
            check("R4 R5 cycle model", win_err, 0);
        end

        // R6: code changes between wraps are ignored.
        do_reset(3'd1);
        win_err = 0;
        for (int i = 0; i < 1200; i++) begin
            if (edge_n % 13 == 5) sel = 3'd0;
            if (edge_n % 13 == 9) sel = 3'd1;
            step();
        end
        check("R6 mid-period code toggles ignored", win_err, 0);

        // R6 R7: switch fast/slow exactly one edge before a wrap, no counter restart.
        do_reset(3'd5);
        win_err = 0;
        t0 = 0;
        for (int i = 0; i < 6000; i++) begin
            if (edge_n % 13 == 12) begin
                t0++;
                if (t0 % 37 == 0) sel = 3'(t0 % 8);
            end
            step();
        end
        check("R6 R7 switch at wrap edge", win_err, 0);

        // R7: slow to fastest mid-run, pulses keep the running wrap count.
        do_reset(3'd7);
        win_err = 0;
        for (int i = 0; i < 100; i++) step();
        sel = 3'd0;
        first_rx = 0;
        for (int i = 0; i < 400; i++) begin
            step();
            if (rxc === 1'b1 && first_rx == 0) first_rx = edge_n;
        end
        check("R7 first fast pulse after switch", first_rx, 104);
        check("R7 cycle model after switch", win_err, 0);

        // R1: reset in mid-run clears outputs and restarts counting.
        do_reset(3'd0);
        win_err = 0;
        for (int i = 0; i < 30; i++) step();
        do_reset(3'd0);
        first_rx = 0;
        for (int i = 0; i < 60; i++) begin
            step();
            if (rxc === 1'b1 && first_rx == 0) first_rx = edge_n;
        end
        check("R1 restart after mid-run reset", first_rx, 26);
        check("R2 R4 model after reset", win_err, 0);

        finish_run();
    end
endmodule